// File: doc/BRIEF.md
# Burst Access Control Unit

This unit sits in front of the storage array of a synchronous burst SRAM and turns the control pins sampled on each rising clock edge into one decision per cycle. That decision has three parts: whether the cycle is a deselect, a read or a write; which array word it addresses; and which byte lanes are written. Two active-low address strobes can start an access. The processor-side strobe always starts a read and is masked when the active-low chip enable is off. The controller-side strobe starts a read or a write, as chosen by the write inputs. When neither strobe is active, an active-low advance input steps a 2-bit burst counter through the four-word group, or holds it in place.

The burst walk is set by a static order strap. In linear order the low two address bits count up with wrap-around. In interleaved order the beat index is XORed into the start offset. A global write forces every configured lane on. Otherwise a byte-write master combined with per-lane enables picks the lanes to write. The decoded result is registered, so the cycle type, the address and the write mask stay constant for the whole clock period that follows the edge at which they were sampled.

Top module: `sbc_top`

## Requirements
- R1: While rst_ni is low, cyc_o is 0 (deselect; the encoding is 0 = deselect, 1 = read, 2 = write), addr_o is 0 and wmask_o is 0.
- R2: A clock edge with proc_strb_ni low, ce_ni low and ce2_i high loads addr_i and gives a read in the cycle that follows that edge. The write inputs and ctrl_strb_ni have no effect on such an edge, and wmask_o is 0.
- R3: proc_strb_ni is ignored when ce_ni is high. An edge with ce_ni high and ctrl_strb_ni low produces a deselect.
- R4: An edge on which either strobe is accepted while ce2_i is low produces a deselect. ce2_i is ignored on edges where neither strobe is accepted.
- R5: An edge with ctrl_strb_ni low (and the processor strobe not accepted), ce_ni low and ce2_i high loads addr_i, and the write decode selects read or write.
- R6: gw_ni low gives a write of every configured lane. Otherwise, bwe_ni low together with one or more low bits of byte_we_ni (bit i drives lane i) writes exactly those lanes. Every other combination is a read with wmask_o equal to 0.
- R7: With order_ilv_i low, each advance raises the two low address bits by one, modulo 4. The upper address bits keep their loaded value.
- R8: With order_ilv_i high, the two low address bits equal the loaded start offset XOR the beat index 0, 1, 2, 3.
- R9: On the fourth advance after a load, the address returns to the loaded start address.
- R10: With both strobes inactive and adv_ni high during an access, the address is held. The cycle type on a continue or hold edge comes from the write decode of that edge.
- R11: After a deselect, edges with no accepted strobe keep the unit deselected and leave the address unchanged.
- R12: Byte lanes at index LANES_USED and above are always 0 in wmask_o, including on a global write.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| proc_strb_ni | input | 1 | Processor-side address strobe, active low, masked by ce_ni |
| ctrl_strb_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high, sampled only with a strobe |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write master, active low |
| byte_we_ni | input | NUM_LANES | Per-lane write enables, active low |
| order_ilv_i | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| cyc_o | output | 2 | Registered cycle type: 0 deselect, 1 read, 2 write |
| addr_o | output | ADDR_W | Registered array address |
| wmask_o | output | NUM_LANES | Registered per-lane write mask, active high |

## Verification
The hardest state to reach is an edge on which the processor strobe is asserted while the chip enable is off. The unit has to treat that strobe as absent and fall into the continue/hold path of an access already in progress. To get there, the stimulus first loads a read with the enables active. It then drops ce_ni and pulls proc_strb_ni low with adv_ni high, and expects the loaded address and a read rather than a fresh load or a deselect. The same kind of setup shows that ce2_i is ignored without a strobe: an access is loaded, then ce2_i is pulled low during an advance, and the counter is expected to step.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    CYC_DESEL = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2,
    ACT_DROP = 2'd3
  } act_e;
endpackage

// File: rtl/sbc_cmd_decode.sv
module sbc_cmd_decode
  import sbc_pkg::*;
(
  input  logic proc_strb_ni,
  input  logic ctrl_strb_ni,
  input  logic adv_ni,
  input  logic ce_ni,
  input  logic ce2_i,
  input  logic active_i,
  output act_e act_o,
  output logic force_rd_o
);
  logic proc_go;
  logic ctrl_go;

  // processor strobe only counts while the primary enable is on
  assign proc_go = !proc_strb_ni && !ce_ni;
  assign ctrl_go = !ctrl_strb_ni;

  always_comb begin
    force_rd_o = 1'b0;
    if (proc_go || ctrl_go) begin
      if (ce_ni || !ce2_i) begin
        act_o = ACT_DROP;
      end else begin
        act_o      = ACT_LOAD;
        force_rd_o = proc_go;
      end
    end else if (!active_i) begin
      act_o = ACT_DROP;
    end else if (!adv_ni) begin
      act_o = ACT_STEP;
    end else begin
      act_o = ACT_HOLD;
    end
  end
endmodule

// File: rtl/sbc_write_merge.sv
module sbc_write_merge #(
  parameter int NUM_LANES  = 4,
  parameter int LANES_USED = 4
) (
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_LANES-1:0] byte_we_ni,
  output logic [NUM_LANES-1:0] mask_o,
  output logic                 wr_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    if (g < LANES_USED) begin : g_used
      assign mask_o[g] = !gw_ni || (!bwe_ni && !byte_we_ni[g]);
    end else begin : g_tied
      assign mask_o[g] = 1'b0;
    end
  end

  assign wr_o = |mask_o;
endmodule

// File: rtl/sbc_burst_seq.sv
module sbc_burst_seq
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  act_e              act_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_ilv_i,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic [1:0]        low;
  logic [HI_W-1:0]   hi;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    case (act_i)
      ACT_LOAD: begin
        base_d = addr_i;
        beat_d = 2'd0;
      end
      ACT_STEP: beat_d = beat_q + 2'd1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  assign low        = order_ilv_i ? (base_d[1:0] ^ beat_d) : (base_d[1:0] + beat_d);
  assign hi         = base_d[ADDR_W-1:2];
  assign nxt_addr_o = {hi, low};
endmodule

// File: rtl/sbc_top.sv
module sbc_top
  import sbc_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int NUM_LANES  = 4,
  parameter int LANES_USED = NUM_LANES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 proc_strb_ni,
  input  logic                 ctrl_strb_ni,
  input  logic                 adv_ni,
  input  logic                 ce_ni,
  input  logic                 ce2_i,
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_LANES-1:0] byte_we_ni,
  input  logic                 order_ilv_i,
  output logic [1:0]           cyc_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [NUM_LANES-1:0] wmask_o
);
  act_e                 act;
  logic                 force_rd;
  logic                 wr;
  logic [NUM_LANES-1:0] mask;
  logic [ADDR_W-1:0]    nxt_addr;
  cyc_e                 cyc_q, cyc_d;
  logic [ADDR_W-1:0]    addr_q;
  logic [NUM_LANES-1:0] mask_q, mask_d;

  sbc_cmd_decode u_dec (
    .proc_strb_ni(proc_strb_ni),
    .ctrl_strb_ni(ctrl_strb_ni),
    .adv_ni      (adv_ni),
    .ce_ni       (ce_ni),
    .ce2_i       (ce2_i),
    .active_i    (cyc_q != CYC_DESEL),
    .act_o       (act),
    .force_rd_o  (force_rd)
  );

  sbc_write_merge #(.NUM_LANES(NUM_LANES), .LANES_USED(LANES_USED)) u_wm (
    .gw_ni     (gw_ni),
    .bwe_ni    (bwe_ni),
    .byte_we_ni(byte_we_ni),
    .mask_o    (mask),
    .wr_o      (wr)
  );

  sbc_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .addr_i     (addr_i),
    .order_ilv_i(order_ilv_i),
    .nxt_addr_o (nxt_addr)
  );

  always_comb begin
    if (act == ACT_DROP)        cyc_d = CYC_DESEL;
    else if (force_rd || !wr)   cyc_d = CYC_READ;
    else                        cyc_d = CYC_WRITE;
    mask_d = (cyc_d == CYC_WRITE) ? mask : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_DESEL;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      addr_q <= nxt_addr;
      mask_q <= mask_d;
    end
  end

  assign cyc_o   = cyc_q;
  assign addr_o  = addr_q;
  assign wmask_o = mask_q;
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk
  import sbc_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int NUM_LANES  = 4,
  parameter int LANES_USED = NUM_LANES
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 proc_strb_ni,
  input logic                 ctrl_strb_ni,
  input logic                 adv_ni,
  input logic                 ce_ni,
  input logic                 ce2_i,
  input logic [1:0]           cyc_o,
  input logic [ADDR_W-1:0]    addr_o,
  input logic [NUM_LANES-1:0] wmask_o
);
  logic no_strb;
  assign no_strb = (proc_strb_ni || ce_ni) && ctrl_strb_ni;

  assert_proc_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strb_ni && !ce_ni && ce2_i) |=> (cyc_o == CYC_READ && addr_o == $past(addr_i)));

  assert_ctrl_off_desel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !ctrl_strb_ni) |=> (cyc_o == CYC_DESEL));

  assert_ce2_desel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !ce2_i && !(proc_strb_ni && ctrl_strb_ni)) |=> (cyc_o == CYC_DESEL));

  assert_mask_only_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o != CYC_WRITE) |-> (wmask_o == '0));

  assert_write_has_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o == CYC_WRITE) |-> (wmask_o != '0));

  assert_step_keeps_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_strb && !adv_ni && cyc_o != CYC_DESEL) |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

  assert_hold_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_strb && adv_ni && cyc_o != CYC_DESEL) |=> $stable(addr_o));

  assert_stay_desel_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_strb && cyc_o == CYC_DESEL) |=> (cyc_o == CYC_DESEL && $stable(addr_o)));

  assert_tied_lanes_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wmask_o >> LANES_USED) == '0));
endmodule

bind sbc_top sbc_chk #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANES_USED(LANES_USED)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .proc_strb_ni(proc_strb_ni),
  .ctrl_strb_ni(ctrl_strb_ni),
  .adv_ni      (adv_ni),
  .ce_ni       (ce_ni),
  .ce2_i       (ce2_i),
  .cyc_o       (cyc_o),
  .addr_o      (addr_o),
  .wmask_o     (wmask_o)
);

// File: tb/sim_sbc_top.sv
`timescale 1ns/1ps
module sim_sbc_top;
  localparam int AW = 18;
  localparam int NL = 4;
  localparam int LU = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [AW-1:0] addr_i;
  logic          proc_strb_ni, ctrl_strb_ni, adv_ni, ce_ni, ce2_i;
  logic          gw_ni, bwe_ni, order_ilv_i;
  logic [NL-1:0] byte_we_ni;
  logic [1:0]    cyc_o;
  logic [AW-1:0] addr_o;
  logic [NL-1:0] wmask_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk_i = ~clk_i;

  sbc_top #(.ADDR_W(AW), .NUM_LANES(NL), .LANES_USED(LU)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .proc_strb_ni(proc_strb_ni), .ctrl_strb_ni(ctrl_strb_ni), .adv_ni(adv_ni),
    .ce_ni(ce_ni), .ce2_i(ce2_i), .gw_ni(gw_ni), .bwe_ni(bwe_ni),
    .byte_we_ni(byte_we_ni), .order_ilv_i(order_ilv_i),
    .cyc_o(cyc_o), .addr_o(addr_o), .wmask_o(wmask_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic [1:0] c, input logic [AW-1:0] a, input logic [NL-1:0] m);
    chk(cyc_o == c, {req, " cyc"}, 32'(cyc_o), 32'(c));
    chk(addr_o == a, {req, " addr"}, 32'(addr_o), 32'(a));
    chk(wmask_o == m, {req, " mask"}, 32'(wmask_o), 32'(m));
  endtask

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle;
    proc_strb_ni = 1'b1; ctrl_strb_ni = 1'b1; adv_ni = 1'b1;
    ce_ni = 1'b0; ce2_i = 1'b1; gw_ni = 1'b1; bwe_ni = 1'b1;
    byte_we_ni = '1;
  endtask

  task automatic load_ctrl_read(input logic [AW-1:0] a);
    idle(); ctrl_strb_ni = 1'b0; addr_i = a;
    tick();
    idle();
  endtask

  task automatic t_reset;
    idle(); order_ilv_i = 1'b0; addr_i = 18'h3ffff;
    #2 rst_ni = 1'b0;
    tick(); tick();
    expect_out("R1", 2'd0, '0, '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_proc_read;
    idle(); proc_strb_ni = 1'b0; ctrl_strb_ni = 1'b0; addr_i = 18'h12345;
    gw_ni = 1'b0; bwe_ni = 1'b0; byte_we_ni = '0;
    tick();
    expect_out("R2", 2'd1, 18'h12345, '0);
    idle();
  endtask

  task automatic t_ce_mask;
    load_ctrl_read(18'h00a40);
    ce_ni = 1'b1; proc_strb_ni = 1'b0; addr_i = 18'h3ff00;
    tick();
    expect_out("R3 masked strobe", 2'd1, 18'h00a40, '0);
    ce_ni = 1'b1; ctrl_strb_ni = 1'b0; proc_strb_ni = 1'b1;
    tick();
    chk(cyc_o == 2'd0, "R3 ctrl with ce off", 32'(cyc_o), 0);
    idle();
  endtask

  task automatic t_ce2;
    idle(); ce2_i = 1'b0; proc_strb_ni = 1'b0; addr_i = 18'h00100;
    tick();
    chk(cyc_o == 2'd0, "R4 ce2 low with strobe", 32'(cyc_o), 0);
    load_ctrl_read(18'h00200);
    ce2_i = 1'b0; adv_ni = 1'b0;
    tick();
    expect_out("R4 ce2 ignored", 2'd1, 18'h00201, '0);
    idle();
  endtask

  task automatic t_write_decode;
    idle(); ctrl_strb_ni = 1'b0; addr_i = 18'h04444; bwe_ni = 1'b0; byte_we_ni = 4'b1010;
    tick();
    expect_out("R5 R6 byte write", 2'd2, 18'h04444, 4'b0101);
    idle(); ctrl_strb_ni = 1'b0; addr_i = 18'h04448; gw_ni = 1'b0; bwe_ni = 1'b1;
    tick();
    expect_out("R6 R12 global write", 2'd2, 18'h04448, 4'b0111);
    idle(); ctrl_strb_ni = 1'b0; addr_i = 18'h0444c; bwe_ni = 1'b0; byte_we_ni = 4'b0111;
    tick();
    expect_out("R12 unused lane only", 2'd1, 18'h0444c, '0);
    idle(); ctrl_strb_ni = 1'b0; addr_i = 18'h04450; bwe_ni = 1'b1; byte_we_ni = '0;
    tick();
    expect_out("R6 master off", 2'd1, 18'h04450, '0);
    idle();
  endtask

  task automatic t_burst(input bit ilv, input logic [AW-1:0] a, input string req);
    logic [1:0] exp_lo;
    order_ilv_i = ilv;
    load_ctrl_read(a);
    chk(addr_o == a, {req, " start"}, 32'(addr_o), 32'(a));
    for (int k = 1; k <= 4; k++) begin
      adv_ni = 1'b0;
      tick();
      exp_lo = ilv ? (a[1:0] ^ 2'(k)) : (a[1:0] + 2'(k));
      chk(addr_o == {a[AW-1:2], exp_lo}, {req, (k == 4) ? " R9 wrap" : " beat"},
          32'(addr_o), 32'({a[AW-1:2], exp_lo}));
    end
    idle();
    order_ilv_i = 1'b0;
  endtask

  task automatic t_suspend;
    load_ctrl_read(18'h08881);
    adv_ni = 1'b0;
    tick();
    adv_ni = 1'b1; gw_ni = 1'b0;
    tick();
    expect_out("R10 hold write", 2'd2, 18'h08882, 4'b0111);
    gw_ni = 1'b1;
    tick();
    expect_out("R10 hold read", 2'd1, 18'h08882, '0);
    idle();
  endtask

  task automatic t_desel_hold;
    load_ctrl_read(18'h01237);
    ce_ni = 1'b1; ctrl_strb_ni = 1'b0;
    tick();
    idle(); adv_ni = 1'b0; gw_ni = 1'b0;
    tick();
    expect_out("R11 stay deselected", 2'd0, 18'h01237, '0);
    idle();
  endtask

  initial begin
    t_reset();
    t_proc_read();
    t_ce_mask();
    t_ce2();
    t_write_decode();
    t_burst(1'b0, 18'h11111, "R7 linear");
    t_burst(1'b1, 18'h22221, "R8 interleaved");
    t_burst(1'b1, 18'h33332, "R8 interleaved b");
    t_suspend();
    t_desel_hold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule